// File: doc/BRIEF.md
# Live Receive Byte Counter

This block keeps a running count of how many bytes of the frame now being received have been written into the receive buffer. The host reads the count while the frame is still arriving and moves that many bytes out. This lets buffer drain overlap frame reception. The line side raises a strobe for each stored byte. It marks the first byte of a frame with a start pulse and the last byte with an end pulse. It also flags the bytes that belong to the trailing frame check sequence (CRC).

A configuration input selects whether CRC bytes are kept in the buffer. The choice is captured when a frame starts, so the count for one frame never mixes the two rules. Once the end pulse has been seen, the count freezes at the final value for the frame. The first host read of that final value sets the count to zero. A host can therefore loop, reading and draining, until it reads zero, and then fetch the frame status elsewhere. Reads taken before the frame ends never disturb the count.

There is no back-pressure on either side. The line side may strobe a byte on every cycle. A host read is a single-cycle strobe that returns the value present on `avail_count` in that cycle.

Top module: `rx_live_byte_count`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `avail_count` is 0.
- R2: Inside an open frame, each cycle with `byte_stb` high and a countable byte raises `avail_count` by exactly 1 at the next clock edge.
- R3: A byte with `byte_is_crc` high is countable only when CRC keeping is on for that frame. When CRC keeping is off, such a byte leaves `avail_count` unchanged.
- R4: CRC keeping for a frame is taken from `keep_crc_cfg` in the `frame_start` cycle. Changes to `keep_crc_cfg` later in the frame have no effect on the count.
- R5: A `host_rd` pulse while the frame is still open leaves `avail_count` unchanged.
- R6: After `frame_end`, and after reset before any `frame_start`, the count ignores byte strobes. It holds its value until it is cleared by a read or by a new frame start.
- R7: A `host_rd` pulse while the count holds a final value (after `frame_end`) makes `avail_count` 0 at the next edge. Later reads keep it at 0.
- R8: `frame_start` restarts the count, even if the previous final value was never read. At the next edge `avail_count` is 1 if a countable byte is strobed in the same cycle, and 0 otherwise.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: A countable byte strobed in the same cycle as `frame_end` is included in the final count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse in the cycle of the first byte of a frame (or just before it) |
| frame_end | input | 1 | Pulse in the cycle of the last byte of a frame |
| byte_stb | input | 1 | One byte has been written to the buffer this cycle |
| byte_is_crc | input | 1 | The strobed byte belongs to the trailing CRC |
| keep_crc_cfg | input | 1 | 1 = CRC bytes are buffered and counted; sampled at frame start |
| host_rd | input | 1 | Host read strobe for the count |
| avail_count | output | CNT_W | Bytes of the current frame available to the host |

## Verification
The table-driven part exercises several patterns. Back-to-back payload strobes show plain counting. Strobes outside a frame, and after its end, separate real frames from idle. CRC bytes are sent under both keeping settings, and the setting is flipped mid-frame; this tells the latched configuration apart from the live pin. Reads are sent before and after the end pulse; this separates a harmless peek from the clearing read. A frame start over an unread final value, and a one-cycle frame where start, end and a byte coincide, show the priority between restart, close and count. Directed runs then push past the counter's top value to show saturation, and assert reset in the middle of a frame.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;

  typedef enum logic [0:0] {
    PH_OPEN   = 1'b0,
    PH_CLOSED = 1'b1
  } rxbc_phase_e;

  function automatic logic is_countable(input logic stb, input logic crc, input logic keep);
    return stb && (!crc || keep);
  endfunction

endpackage

// File: rtl/rxbc_qualify.sv
module rxbc_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic byte_stb,
  input  logic byte_is_crc,
  input  logic keep_crc_cfg,
  output logic countable
);
  import rxbc_pkg::*;

  logic keep_q;
  logic keep_eff;

  // CRC policy is captured once per frame; the start cycle itself uses the live pin.
  always_ff @(posedge clk) begin
    if (!rst_n)           keep_q <= 1'b0;
    else if (frame_start) keep_q <= keep_crc_cfg;
  end

  assign keep_eff  = frame_start ? keep_crc_cfg : keep_q;
  assign countable = is_countable(byte_stb, byte_is_crc, keep_eff);

endmodule

// File: rtl/rxbc_phase.sv
module rxbc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_end,
  output logic closed
);
  import rxbc_pkg::*;

  rxbc_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (frame_end)        ph_d = PH_CLOSED;
    else if (frame_start) ph_d = PH_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_CLOSED;
    else        ph_q <= ph_d;
  end

  assign closed = (ph_q == PH_CLOSED);

endmodule

// File: rtl/rxbc_counter.sv
module rxbc_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = load_one ? ONE : '0;
    else if (inc && cnt_q != TOP) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign q = cnt_q;

endmodule

// File: rtl/rx_live_byte_count.sv
module rx_live_byte_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             byte_stb,
  input  logic             byte_is_crc,
  input  logic             keep_crc_cfg,
  input  logic             host_rd,
  output logic [CNT_W-1:0] avail_count
);

  logic countable;
  logic closed;
  logic clr;
  logic inc;

  rxbc_qualify u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .byte_stb     (byte_stb),
    .byte_is_crc  (byte_is_crc),
    .keep_crc_cfg (keep_crc_cfg),
    .countable    (countable)
  );

  rxbc_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .closed      (closed)
  );

  // Restart wins over everything; a read only clears once the value is final.
  assign clr = frame_start || (closed && host_rd);
  assign inc = countable && !closed;

  rxbc_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load_one (frame_start && countable),
    .inc      (inc),
    .q        (avail_count)
  );

endmodule

// File: rtl/rx_live_byte_count_chk.sv
module rx_live_byte_count_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             frame_end,
  input logic             byte_stb,
  input logic             byte_is_crc,
  input logic             keep_crc_cfg,
  input logic             host_rd,
  input logic [CNT_W-1:0] avail_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic shut_q;
  logic keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shut_q <= 1'b1;
      keep_q <= 1'b0;
    end else begin
      if (frame_end)        shut_q <= 1'b1;
      else if (frame_start) shut_q <= 1'b0;
      if (frame_start)      keep_q <= keep_crc_cfg;
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q && !frame_start && byte_stb && !byte_is_crc && avail_count != TOP)
    |=> avail_count == $past(avail_count) + 1'b1); // R2

  AST_CRC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q && !frame_start && byte_stb && byte_is_crc && !keep_q)
    |=> $stable(avail_count)); // R3

  AST_PEEK_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q && !frame_start && !byte_stb)
    |=> $stable(avail_count)); // R5

  AST_FINAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !frame_start && !host_rd)
    |=> $stable(avail_count)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !frame_start && host_rd)
    |=> avail_count == '0); // R7

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !byte_stb)
    |=> avail_count == '0); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_count == TOP && !frame_start && !host_rd)
    |=> avail_count == TOP); // R9

endmodule

bind rx_live_byte_count rx_live_byte_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .frame_end    (frame_end),
  .byte_stb     (byte_stb),
  .byte_is_crc  (byte_is_crc),
  .keep_crc_cfg (keep_crc_cfg),
  .host_rd      (host_rd),
  .avail_count  (avail_count)
);

// File: tb/rx_live_byte_count_tb.sv
module rx_live_byte_count_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int NVEC       = 22;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // {req[3:0], sof, eof, stb, crc, keep, rd, expected count after the edge}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd6,  6'b001000, 12'd0},  // R6 byte before any frame ignored
    {4'd8,  6'b101010, 12'd1},  // R8 start with byte counts as 1
    {4'd2,  6'b001010, 12'd2},  // R2
    {4'd5,  6'b001011, 12'd3},  // R5 read mid-frame, byte still counts
    {4'd5,  6'b000001, 12'd3},  // R5 read mid-frame, no clear
    {4'd3,  6'b001110, 12'd4},  // R3 CRC byte kept
    {4'd10, 6'b011100, 12'd5},  // R10 byte with end is included
    {4'd6,  6'b001000, 12'd5},  // R6 byte after end ignored
    {4'd6,  6'b000000, 12'd5},  // R6 hold
    {4'd7,  6'b000001, 12'd0},  // R7 read of final clears
    {4'd7,  6'b000001, 12'd0},  // R7 stays zero
    {4'd8,  6'b101000, 12'd1},  // R8 new frame, CRC keeping off
    {4'd4,  6'b001010, 12'd2},  // R4 cfg flipped mid-frame
    {4'd4,  6'b001110, 12'd2},  // R4 CRC still dropped
    {4'd3,  6'b001100, 12'd2},  // R3 CRC dropped
    {4'd3,  6'b011100, 12'd2},  // R3 last CRC byte with end dropped
    {4'd8,  6'b100010, 12'd0},  // R8 restart over unread final
    {4'd2,  6'b001000, 12'd1},  // R2
    {4'd8,  6'b101000, 12'd1},  // R8 restart mid-frame
    {4'd10, 6'b111000, 12'd1},  // R10 one-cycle frame
    {4'd7,  6'b000001, 12'd0},  // R7
    {4'd6,  6'b001000, 12'd0}   // R6 closed, byte ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, byte_stb = 1'b0;
  logic byte_is_crc = 1'b0, keep_crc_cfg = 1'b0, host_rd = 1'b0;
  logic [CNT_W-1:0] avail_count;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_live_byte_count #(.CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .byte_stb     (byte_stb),
    .byte_is_crc  (byte_is_crc),
    .keep_crc_cfg (keep_crc_cfg),
    .host_rd      (host_rd),
    .avail_count  (avail_count)
  );

  task automatic check(input int req, input logic [CNT_W-1:0] exp);
    n_checks++;
    if (avail_count !== exp) begin
      n_errors++;
      $display("FAIL R%0d: avail_count=%0d expected=%0d at %0t", req, avail_count, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] b);
    {frame_start, frame_end, byte_stb, byte_is_crc, keep_crc_cfg, host_rd} = b;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(1, '0);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, '0);  // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][17:12]);
      @(negedge clk);
      check(int'(VEC[i][21:18]), VEC[i][11:0]);
    end
    drive(6'b0);

    // R9 saturation
    drive(6'b101000);
    @(negedge clk);
    drive(6'b001000);
    for (int i = 0; i < 4100; i++) @(negedge clk);
    check(9, TOP);
    drive(6'b000001);  // R5 read before end keeps saturated value
    @(negedge clk);
    check(5, TOP);
    drive(6'b011000);
    @(negedge clk);
    check(9, TOP);
    drive(6'b000001);
    @(negedge clk);
    check(7, '0);

    // R1 reset mid-frame
    drive(6'b101000);
    @(negedge clk);
    drive(6'b001000);
    @(negedge clk);
    check(2, 12'd2);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, '0);
    drive(6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule